// File: doc/BRIEF.md
# Sixteen-Slot Tag Inventory Sequencer

This block runs a complete sixteen-slot tag inventory after a single trigger from the host, with no further host involvement. It first issues a call command, which opens slot 0. It then issues slot-marker commands for slots 1 to 15 in ascending order. After each command it stalls until the receive side reports how that slot ended. There are three outcomes: a clean answer carrying a one-byte chip identifier, an answer with a CRC error (typically two tags answering at once), or no answer at all.

Each slot's outcome is written into a shared nineteen-byte result area of the frame buffer. Byte 0 is a length byte and always reads 18. Bytes 1 and 2 form a validity bitmap. Bytes 3 to 18 are one byte per slot. A slot byte holds the chip identifier for a clean answer, FFh for a corrupted answer and 00h for silence.

The host never reads the trigger. It collects everything from the frame buffer. The exact command byte values are set by parameters. The RF coding sits outside this block.

Top module: `anticol_seq`

## Requirements
- R1: While reset is held, and on leaving it, `busy_o`, `tx_valid_o` and `buf_we_o` are all 0.
- R2: A `start_i` pulse seen while idle raises `busy_o` on the next cycle. In that same cycle `tx_valid_o` is 1 and `tx_cmd_o` equals the call code (parameter `CALL_CODE`, default 8'h06).
- R3: Commands are issued in this order: the call code for slot 0, then `{MARK_HI, slot}` for slots 1 to 15 in ascending order. The slot number sits in bits 3:0 and `MARK_HI` (default 4'h6) in bits 7:4. After an accepted command, no further command is offered until an answer report (`rx_valid_i`) has arrived.
- R4: An answer report with `rx_status_i` = 2'b00 (clean) writes `rx_data_i` to buffer byte 3+slot and sets that slot's bitmap bit to 1.
- R5: An answer report with `rx_status_i` = 2'b10 or 2'b11 (no answer) writes 00h to byte 3+slot and leaves that slot's bitmap bit at 0.
- R6: An answer report with `rx_status_i` = 2'b01 (CRC error) writes FFh to byte 3+slot and leaves that slot's bitmap bit at 0.
- R7: After slot 15 resolves, the block writes bytes 1, 2 and then 0. Byte 0 gets the value 18 and is the last write, so a complete inventory makes exactly 19 writes.
- R8: Byte 1 holds the bitmap bits for slots 7..0, with slot 0 in bit 0. Byte 2 holds the bits for slots 15..8, with slot 8 in bit 0.
- R9: `busy_o` stays 1 from the trigger until the length byte has been written. While idle, the block neither offers a command nor writes the buffer.
- R10: A `start_i` pulse that arrives while busy is ignored: the running sequence is unchanged and no new sequence follows it.
- R11: An offered command holds `tx_valid_o` at 1 and keeps `tx_cmd_o` stable until `tx_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Inventory trigger pulse |
| busy_o | output | 1 | Inventory in progress |
| tx_valid_o | output | 1 | Command offered to the transmitter |
| tx_ready_i | input | 1 | Transmitter accepts the command |
| tx_cmd_o | output | 8 | Command byte |
| rx_valid_i | input | 1 | One-cycle answer report for the current slot |
| rx_status_i | input | 2 | 00 clean, 01 CRC error, 1x no answer |
| rx_data_i | input | 8 | Chip identifier (used only when clean) |
| buf_we_o | output | 1 | Frame buffer write strobe |
| buf_addr_o | output | 5 | Frame buffer byte address |
| buf_wdata_o | output | 8 | Frame buffer write data |

## Verification
The assertions take for granted that the receive side raises `rx_valid_i` only after a command has been accepted, for exactly one cycle per command. They also assume `rx_status_i` and `rx_data_i` are meaningful only in that cycle. The directed stimulus follows this rule throughout: it answers only after the handshake completes and after the bench has seen `tx_valid_o` drop. No scenario ever produces a second answer for the same slot. Triggers that arrive while busy are deliberately placed mid-sequence.

// File: rtl/anticol_pkg.sv
package anticol_pkg;
  localparam int SLOTS     = 16;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int HDR_BYTES = 3;
  localparam int RES_BYTES = SLOTS + HDR_BYTES;
  localparam int ADDR_W    = $clog2(RES_BYTES);
  localparam int BYTE_W    = 8;

  localparam logic [1:0] ANS_CLEAN = 2'b00;
  localparam logic [1:0] ANS_CRC   = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_HDR} seq_state_e;

  // Result byte for one slot from its answer report.
  function automatic logic [BYTE_W-1:0] slot_byte(input logic [1:0] st,
                                                  input logic [BYTE_W-1:0] id);
    if (st == ANS_CLEAN)    return id;
    else if (st == ANS_CRC) return '1;
    else                    return '0;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
    return ADDR_W'(HDR_BYTES) + ADDR_W'(s);
  endfunction

  // Header write order: bitmap low, bitmap high, then length last.
  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [1:0] idx);
    case (idx)
      2'd0:    return ADDR_W'(1);
      2'd1:    return ADDR_W'(2);
      default: return ADDR_W'(0);
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] hdr_data(input logic [1:0] idx,
                                                 input logic [SLOTS-1:0] map);
    case (idx)
      2'd0:    return map[7:0];
      2'd1:    return map[15:8];
      default: return BYTE_W'(RES_BYTES - 1);
    endcase
  endfunction
endpackage

// File: rtl/anticol_ctrl.sv
module anticol_ctrl
  import anticol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  output logic              send_phase,
  output logic              hdr_phase,
  output logic              start_acc,
  output logic              slot_done,
  output logic [SLOT_W-1:0] slot_q,
  output logic [1:0]        hdr_idx,
  output logic              busy
);
  seq_state_e state_q;
  logic       last_slot;

  assign start_acc  = start_i && (state_q == ST_IDLE);
  assign slot_done  = rx_valid_i && (state_q == ST_WAIT);
  assign last_slot  = (slot_q == SLOT_W'(SLOTS - 1));
  assign send_phase = (state_q == ST_SEND);
  assign hdr_phase  = (state_q == ST_HDR);
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      hdr_idx <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q <= ST_SEND;
          slot_q  <= '0;
        end
        ST_SEND: if (tx_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rx_valid_i) begin
          if (last_slot) begin
            state_q <= ST_HDR;
            hdr_idx <= '0;
          end else begin
            state_q <= ST_SEND;
            slot_q  <= slot_q + SLOT_W'(1);
          end
        end
        ST_HDR: begin
          if (hdr_idx == 2'(HDR_BYTES - 1)) state_q <= ST_IDLE;
          else hdr_idx <= hdr_idx + 2'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/anticol_status.sv
module anticol_status
  import anticol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mark,
  input  logic [SLOT_W-1:0] slot,
  output logic [SLOTS-1:0]  map
);
  always_ff @(posedge clk) begin
    if (!rst_n)     map <= '0;
    else if (clear) map <= '0;
    else if (mark)  map[slot] <= 1'b1;
  end
endmodule

// File: rtl/anticol_writer.sv
module anticol_writer
  import anticol_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CALL_CODE = 8'h06,
  parameter logic [3:0]        MARK_HI   = 4'h6
) (
  input  logic              send_phase,
  input  logic              hdr_phase,
  input  logic              slot_done,
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        hdr_idx,
  input  logic [SLOTS-1:0]  map,
  input  logic [1:0]        rx_status,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_cmd,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [BYTE_W-1:0] buf_wdata
);
  assign tx_valid = send_phase;
  assign tx_cmd   = (slot == '0) ? CALL_CODE : {MARK_HI, slot};
  assign buf_we   = slot_done || hdr_phase;

  always_comb begin
    if (hdr_phase) begin
      buf_addr  = hdr_addr(hdr_idx);
      buf_wdata = hdr_data(hdr_idx, map);
    end else begin
      buf_addr  = slot_addr(slot);
      buf_wdata = slot_byte(rx_status, rx_data);
    end
  end
endmodule

// File: rtl/anticol_seq.sv
module anticol_seq
  import anticol_pkg::*;
#(
  parameter logic [7:0] CALL_CODE = 8'h06,
  parameter logic [3:0] MARK_HI   = 4'h6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       busy_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_cmd_o,
  input  logic       rx_valid_i,
  input  logic [1:0] rx_status_i,
  input  logic [7:0] rx_data_i,
  output logic       buf_we_o,
  output logic [4:0] buf_addr_o,
  output logic [7:0] buf_wdata_o
);
  logic              send_phase, hdr_phase, start_acc, slot_done, slot_good;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        hdr_idx;
  logic [SLOTS-1:0]  valid_map;

  assign slot_good = slot_done && (rx_status_i == ANS_CLEAN);

  anticol_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_ready_i(tx_ready_i),
    .rx_valid_i(rx_valid_i), .send_phase(send_phase), .hdr_phase(hdr_phase),
    .start_acc(start_acc), .slot_done(slot_done), .slot_q(slot_q),
    .hdr_idx(hdr_idx), .busy(busy_o)
  );

  anticol_status status_i (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .mark(slot_good),
    .slot(slot_q), .map(valid_map)
  );

  anticol_writer #(.CALL_CODE(CALL_CODE), .MARK_HI(MARK_HI)) writer_i (
    .send_phase(send_phase), .hdr_phase(hdr_phase), .slot_done(slot_done),
    .slot(slot_q), .hdr_idx(hdr_idx), .map(valid_map),
    .rx_status(rx_status_i), .rx_data(rx_data_i), .tx_valid(tx_valid_o),
    .tx_cmd(tx_cmd_o), .buf_we(buf_we_o), .buf_addr(buf_addr_o),
    .buf_wdata(buf_wdata_o)
  );
endmodule

// File: rtl/anticol_seq_chk.sv
module anticol_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_cmd_o,
  input logic [1:0] rx_status_i,
  input logic [7:0] rx_data_i,
  input logic       buf_we_o,
  input logic [4:0] buf_addr_o,
  input logic [7:0] buf_wdata_o,
  input logic       slot_done,
  input logic [3:0] slot_q
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && tx_valid_o)); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid_o, buf_we_o})); // R3
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && slot_q != 4'd15) |=> (tx_valid_o && tx_cmd_o[3:0] == $past(slot_q) + 4'd1)); // R3
  AST_CLEAN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && rx_status_i == 2'b00) |-> (buf_we_o && buf_wdata_o == rx_data_i)); // R4
  AST_SILENT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && rx_status_i[1]) |-> (buf_we_o && buf_wdata_o == 8'h00)); // R5
  AST_CRC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done && rx_status_i == 2'b01) |-> (buf_we_o && buf_wdata_o == 8'hFF)); // R6
  AST_LEN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we_o && buf_addr_o == 5'd0) |-> (buf_wdata_o == 8'd18)); // R7
  AST_LEN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we_o && buf_addr_o == 5'd0) |=> !busy_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tx_valid_o && !buf_we_o)); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_cmd_o))); // R11
endmodule

bind anticol_seq anticol_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_cmd_o(tx_cmd_o),
  .rx_status_i(rx_status_i), .rx_data_i(rx_data_i), .buf_we_o(buf_we_o),
  .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o),
  .slot_done(slot_done), .slot_q(slot_q)
);

// File: tb/anticol_seq_tb.sv
module anticol_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] CALL = 8'h06;
  localparam logic [3:0] MHI  = 4'h6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [1:0] rx_status_i = '0;
  logic [7:0] rx_data_i = '0;
  logic busy_o, tx_valid_o, buf_we_o;
  logic [7:0] tx_cmd_o, buf_wdata_o;
  logic [4:0] buf_addr_o;

  int n_vec = 0, n_bad = 0;
  logic [7:0] mem [0:18];
  int wr_cnt;
  logic [4:0] last_addr;
  logic [1:0] pat_st [0:15];
  logic [7:0] pat_id [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  anticol_seq #(.CALL_CODE(CALL), .MARK_HI(MHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_cmd_o(tx_cmd_o),
    .rx_valid_i(rx_valid_i), .rx_status_i(rx_status_i), .rx_data_i(rx_data_i),
    .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o)
  );

  // Frame buffer model
  always @(posedge clk) begin
    if (buf_we_o) begin
      if (buf_addr_o < 5'd19) mem[buf_addr_o] <= buf_wdata_o;
      wr_cnt    <= wr_cnt + 1;
      last_addr <= buf_addr_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_slot(input logic [1:0] st, input logic [7:0] id);
    case (st)
      2'b00:   return id;
      2'b01:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_cmd(input int s);
    return (s == 0) ? CALL : {MHI, 4'(s)};
  endfunction

  // One full inventory against the pattern in pat_st/pat_id.
  task automatic run_inventory(input string name, input int ready_lag, input bit retrig);
    logic [15:0] emap;
    for (int i = 0; i < 19; i++) mem[i] = 8'hAA;
    wr_cnt = 0;
    emap = '0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", {name, " busy after trigger"}, busy_o, 1);
    chk(tx_valid_o && tx_cmd_o == CALL, "R2", {name, " first command"}, tx_cmd_o, CALL);
    for (int s = 0; s < 16; s++) begin
      int w = 0;
      while (!tx_valid_o && w < 40) begin @(negedge clk); w++; end
      chk(tx_valid_o && tx_cmd_o == exp_cmd(s), "R3", $sformatf("%s slot %0d command", name, s),
          tx_cmd_o, exp_cmd(s));
      if (ready_lag > 0) begin
        repeat (ready_lag) @(negedge clk);
        chk(tx_valid_o && tx_cmd_o == exp_cmd(s), "R11", $sformatf("%s slot %0d held", name, s),
            tx_cmd_o, exp_cmd(s));
      end
      if (retrig && s == 5) start_i = 1'b1;
      tx_ready_i = 1'b1;
      @(negedge clk); tx_ready_i = 1'b0; start_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(!tx_valid_o, "R3", $sformatf("%s slot %0d waits for answer", name, s), tx_valid_o, 0);
      if (retrig && s == 5)
        chk(busy_o, "R10", {name, " retrigger keeps sequence"}, busy_o, 1);
      rx_valid_i = 1'b1; rx_status_i = pat_st[s]; rx_data_i = pat_id[s];
      @(negedge clk); rx_valid_i = 1'b0; rx_status_i = 2'b00; rx_data_i = 8'h00;
      if (pat_st[s] == 2'b00) emap[s] = 1'b1;
    end
    begin
      int w = 0;
      while (busy_o && w < 40) begin @(negedge clk); w++; end
    end
    chk(!busy_o, "R9", {name, " busy cleared at end"}, busy_o, 0);
    for (int s = 0; s < 16; s++) begin
      string rq;
      rq = (pat_st[s] == 2'b00) ? "R4" : (pat_st[s] == 2'b01) ? "R6" : "R5";
      chk(mem[3+s] == exp_slot(pat_st[s], pat_id[s]), rq,
          $sformatf("%s slot byte %0d", name, s), mem[3+s], exp_slot(pat_st[s], pat_id[s]));
    end
    chk(mem[1] == emap[7:0], "R8", {name, " bitmap low byte"}, mem[1], emap[7:0]);
    chk(mem[2] == emap[15:8], "R8", {name, " bitmap high byte"}, mem[2], emap[15:8]);
    chk(mem[0] == 8'd18, "R7", {name, " length byte"}, mem[0], 18);
    chk(last_addr == 5'd0, "R7", {name, " length written last"}, last_addr, 0);
    chk(wr_cnt == 19, "R7", {name, " write count"}, wr_cnt, 19);
    if (retrig) begin
      repeat (4) @(negedge clk);
      chk(!busy_o && !tx_valid_o, "R10", {name, " no restart after retrigger"},
          {busy_o, tx_valid_o}, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !tx_valid_o && !buf_we_o, "R1", "outputs in reset",
        {busy_o, tx_valid_o, buf_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !tx_valid_o && !buf_we_o, "R1", "outputs after reset",
        {busy_o, tx_valid_o, buf_we_o}, 0);
  endtask

  task automatic t_all_clean();
    for (int s = 0; s < 16; s++) begin pat_st[s] = 2'b00; pat_id[s] = 8'h10 + 8'(s); end
    run_inventory("all clean", 0, 1'b0); // R4 R8
  endtask

  task automatic t_all_silent();
    for (int s = 0; s < 16; s++) begin
      pat_st[s] = (s % 2 == 0) ? 2'b10 : 2'b11; pat_id[s] = 8'h5A;
    end
    run_inventory("all silent", 0, 1'b0); // R5
  endtask

  task automatic t_mixed();
    for (int s = 0; s < 16; s++) begin
      pat_st[s] = (s % 3 == 0) ? 2'b00 : (s % 3 == 1) ? 2'b01 : 2'b10;
      pat_id[s] = 8'hC0 | 8'(s);
    end
    run_inventory("mixed lagged", 2, 1'b1); // R6 R10 R11
  endtask

  task automatic t_edge_ids();
    for (int s = 0; s < 16; s++) begin pat_st[s] = 2'b01; pat_id[s] = 8'h33; end
    pat_st[0] = 2'b00;  pat_id[0] = 8'hFF;
    pat_st[8] = 2'b00;  pat_id[8] = 8'h81;
    pat_st[15] = 2'b00; pat_id[15] = 8'h00;
    run_inventory("edge ids", 1, 1'b0); // R4 R8
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_all_clean();
    t_all_silent();
    t_mixed();
    t_edge_ids();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule